// File: doc/BRIEF.md
# Offload Multiply Unit

This block sits beside a small CPU core and executes the four 32-bit multiply instructions on its behalf. The host presents an offload request as a valid strobe, the full instruction word and the two source operand values. When the word is one of the multiply forms, the unit claims the request by raising its wait flag and grinds through a shift-add multiplication, one multiplier bit per clock. It then pulses ready together with a write flag and the 32-bit result.

Any other instruction word is left untouched: the unit stays quiet, so that the host's own offload timeout can trap the word as illegal. The host picks the destination register and performs the write-back. The unit only returns the value.

The low-half product needs 32 iterations. The three high-half products need 64 iterations over operands extended to 64 bits. This gives a fixed latency for each operation class. If the host withdraws valid while a computation is running, the unit abandons the computation and returns to idle.

Top module: `copro_mul`

## Requirements
- R1: After reset, wait, ready and the write flag are all low.
- R2: An instruction word is recognised when its bits 6:0 equal 0110011, its bits 31:25 equal 0000001 and its bits 14:12 lie in 000..011. When such a word is first sampled with valid high, wait is high in the next cycle.
- R3: With valid high and a word that is not recognised (another opcode, another funct7, or bits 14:12 in 100..111), wait and ready stay low for as long as valid is held.
- R4: Function code 000 returns bits 31:0 of the product of the two operands.
- R5: Function code 001 returns bits 63:32 of the product, with both operands taken as signed.
- R6: Function code 010 returns bits 63:32 of the product, with the first operand signed and the second operand unsigned.
- R7: Function code 011 returns bits 63:32 of the product, with both operands unsigned.
- R8: Ready rises a fixed number of cycles after the clock edge that first samples a recognised request. The count is 33 cycles for code 000 and 65 cycles for codes 001..011.
- R9: Wait stays high in every cycle from the cycle after acceptance up to the ready cycle, and is low in the ready cycle. Ready is a one-cycle pulse that coincides with the write flag and the valid result.
- R10: If valid is low at a clock edge while a computation is running, wait is low in the next cycle, no ready follows, and a later request is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host offers an instruction |
| reqInsn | input | 32 | Instruction word |
| reqOpA | input | 32 | First source operand value |
| reqOpB | input | 32 | Second source operand value |
| rspWrite | output | 1 | Result is to be written back |
| rspData | output | 32 | Result value (zero outside the ready cycle) |
| rspWait | output | 1 | Unit has claimed the instruction and is busy |
| rspReady | output | 1 | Instruction complete |

## Verification
The bench uses operand pairs whose sign bits are set, so that each high-half variant gives a different answer. A design that mixes up which operand is signed, or that fails to sign-extend, returns a wrong upper word (for example 0xc0000000 against 0x40000000 for 0x80000000 squared). Every result is timed against the exact cycle count of its class, so an off-by-one in the iteration counter, or a swap of the low and high counts, shows up as a latency mismatch. Near-miss instruction words (the wrong opcode, a zero funct7, the divide function codes) are held valid for well past the host timeout; a decoder that is too loose would raise wait on them. A request withdrawn in mid-run must leave no stray ready pulse behind. The request that follows it must return the correct product.

// File: rtl/copro_mul_pkg.sv
package copro_mul_pkg;

  localparam logic [6:0] OPC_REG_OP = 7'b0110011;
  localparam logic [6:0] F7_MULDIV  = 7'b0000001;

  typedef struct packed {
    logic load;
    logic step;
    logic signA;
    logic signB;
    logic takeHigh;
  } mulStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mulState_t;

endpackage

// File: rtl/copro_mul_ctrl.sv
module copro_mul_ctrl
  import copro_mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqInsn,
  output mulStrobe_t  strobe,
  output logic        busyWait,
  output logic        doneReady
);

  localparam int LO_STEPS = XLEN;
  localparam int HI_STEPS = 2 * XLEN;
  localparam int CNT_W    = $clog2(HI_STEPS);
  localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(LO_STEPS - 1);
  localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(HI_STEPS - 1);

  mulState_t        state;
  logic [CNT_W-1:0] stepCnt;
  logic [CNT_W-1:0] lastIdx;
  logic             hit;
  logic [1:0]       func;
  logic             isHigh;

  // decode of the offered instruction word
  assign func   = reqInsn[13:12];
  assign hit    = (reqInsn[6:0] == OPC_REG_OP) && (reqInsn[31:25] == F7_MULDIV) && !reqInsn[14];
  assign isHigh = (func != 2'b00);

  always_comb begin
    strobe.load     = (state == ST_IDLE) && reqValid && hit;
    strobe.step     = (state == ST_RUN) && reqValid;
    strobe.signA    = (func == 2'b01) || (func == 2'b10);
    strobe.signB    = (func == 2'b01);
    strobe.takeHigh = isHigh;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      lastIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid && hit) begin
            state   <= ST_RUN;
            stepCnt <= '0;
            lastIdx <= isHigh ? HI_LAST : LO_LAST;
          end
        end
        ST_RUN: begin
          if (!reqValid) begin
            state <= ST_IDLE;
          end else if (stepCnt == lastIdx) begin
            state <= ST_DONE;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busyWait  = (state == ST_RUN);
  assign doneReady = (state == ST_DONE);

  // R2
  wait_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyWait) |-> $past(reqValid && hit));

  // R3
  ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !hit && !busyWait && !doneReady) |=> !busyWait);

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneReady |=> !doneReady);

  // R9
  ready_after_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneReady |-> $past(busyWait));

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyWait && !reqValid) |=> (!busyWait && !doneReady));

endmodule

// File: rtl/copro_mul_dp.sv
module copro_mul_dp
  import copro_mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  mulStrobe_t      strobe,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic [XLEN-1:0] result
);

  localparam int WIDE = 2 * XLEN;

  logic [WIDE-1:0] acc;
  logic [WIDE-1:0] mcand;
  logic [WIDE-1:0] mplier;
  logic            hiSel;
  logic [WIDE-1:0] extA;
  logic [WIDE-1:0] extB;

  // widen each operand, with or without sign
  assign extA = {{XLEN{strobe.signA & opA[XLEN-1]}}, opA};
  assign extB = {{XLEN{strobe.signB & opB[XLEN-1]}}, opB};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      hiSel  <= 1'b0;
    end else if (strobe.load) begin
      acc    <= '0;
      mcand  <= extA;
      mplier <= extB;
      hiSel  <= strobe.takeHigh;
    end else if (strobe.step) begin
      if (mplier[0]) acc <= acc + mcand;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
    end
  end

  assign result = hiSel ? acc[WIDE-1:XLEN] : acc[XLEN-1:0];

  // R4 after loading, the accumulator starts its first step from zero
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (acc == '0));

endmodule

// File: rtl/copro_mul.sv
module copro_mul
  import copro_mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [31:0]     reqInsn,
  input  logic [XLEN-1:0] reqOpA,
  input  logic [XLEN-1:0] reqOpB,
  output logic            rspWrite,
  output logic [XLEN-1:0] rspData,
  output logic            rspWait,
  output logic            rspReady
);

  mulStrobe_t      strobe;
  logic            busyWait;
  logic            doneReady;
  logic [XLEN-1:0] result;

  copro_mul_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqInsn  (reqInsn),
    .strobe   (strobe),
    .busyWait (busyWait),
    .doneReady(doneReady)
  );

  copro_mul_dp #(.XLEN(XLEN)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .opA   (reqOpA),
    .opB   (reqOpB),
    .result(result)
  );

  assign rspWait  = busyWait;
  assign rspReady = doneReady;
  assign rspWrite = doneReady;
  assign rspData  = doneReady ? result : '0;

endmodule

// File: tb/copro_mul_bench.sv
module copro_mul_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LAT_LO = 33;
  localparam int LAT_HI = 65;

  typedef struct {
    logic [31:0] data;
    int          lat;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqInsn = '0;
  logic [31:0] reqOpA = '0;
  logic [31:0] reqOpB = '0;
  logic        rspWrite;
  logic [31:0] rspData;
  logic        rspWait;
  logic        rspReady;

  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;
  int          startCyc = 0;
  expItem_t    expQ[$];

  copro_mul u_copro_mul (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqInsn(reqInsn),
    .reqOpA(reqOpA), .reqOpB(reqOpB), .rspWrite(rspWrite), .rspData(rspData),
    .rspWait(rspWait), .rspReady(rspReady)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkInsn(input logic [6:0] f7, input logic [2:0] f3, input logic [6:0] opc);
    return {f7, 5'd2, 5'd1, f3, 5'd3, opc};
  endfunction

  function automatic logic [31:0] refMul(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] sa, sb, ua, ub, p;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    ua = {32'b0, a};
    ub = {32'b0, b};
    case (f3)
      3'b000:  p = ua * ub;
      3'b001:  p = sa * sb;
      3'b010:  p = sa * ub;
      default: p = ua * ub;
    endcase
    return (f3 == 3'b000) ? p[31:0] : p[63:32];
  endfunction

  // monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (rstN && rspReady) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R10 unexpected ready", 64'(rspData), 64'h0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        chk(rspData == it.data, it.tag, 64'(rspData), 64'(it.data));
        chk((cyc - startCyc) == it.lat, "R8 latency", 64'(cyc - startCyc), 64'(it.lat));
        chk(rspWrite == 1'b1, "R9 write with ready", 64'(rspWrite), 64'h1);
      end
    end
  end

  // driver: queues the expectation and runs one request to completion
  task automatic runOp(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b, input string tag);
    expItem_t it;
    bit waitOk;
    bit seen;
    int n;
    it.data = refMul(f3, a, b);
    it.lat  = (f3 == 3'b000) ? LAT_LO : LAT_HI;
    it.tag  = tag;
    expQ.push_back(it);
    @(negedge clk);
    reqInsn  = mkInsn(7'b0000001, f3, 7'b0110011);
    reqOpA   = a;
    reqOpB   = b;
    reqValid = 1'b1;
    startCyc = cyc;
    waitOk = 1'b1;
    seen = 1'b0;
    n = 0;
    while (!seen && n < 200) begin
      @(negedge clk);
      n++;
      if (n == 1) chk(rspWait == 1'b1, "R2 wait after accept", 64'(rspWait), 64'h1);
      if (rspReady) begin
        seen = 1'b1;
        chk(rspWait == 1'b0, "R9 wait low in ready cycle", 64'(rspWait), 64'h0);
      end else if (!rspWait) begin
        waitOk = 1'b0;
      end
    end
    chk(waitOk && seen, "R9 wait held until ready", 64'(waitOk), 64'h1);
    reqValid = 1'b0;
  endtask

  task automatic idleOp(input logic [31:0] insn, input string tag);
    bit quiet;
    @(negedge clk);
    reqInsn  = insn;
    reqOpA   = 32'h1234_5678;
    reqOpB   = 32'h9abc_def0;
    reqValid = 1'b1;
    quiet = 1'b1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (rspWait || rspReady) quiet = 1'b0;
    end
    chk(quiet, tag, 64'(quiet), 64'h1);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'h0, 64'h1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rspWait && !rspReady && !rspWrite, "R1 reset outputs", 64'({rspWait, rspReady, rspWrite}), 64'h0);
    rstN = 1'b1;

    runOp(3'b000, 32'd3, 32'd5, "R4 low product small");
    runOp(3'b000, 32'hffff_ffff, 32'hffff_ffff, "R4 low product all ones");
    runOp(3'b000, 32'h8000_0000, 32'd2, "R4 low product overflow");
    runOp(3'b000, 32'hdead_beef, 32'h1357_9bdf, "R4 low product mixed");
    runOp(3'b001, 32'hffff_ffff, 32'hffff_ffff, "R5 signed high minus one squared");
    runOp(3'b001, 32'h8000_0000, 32'h8000_0000, "R5 signed high min squared");
    runOp(3'b001, 32'hffff_fffd, 32'd7, "R5 signed high negative times positive");
    runOp(3'b010, 32'hffff_ffff, 32'hffff_ffff, "R6 mixed high");
    runOp(3'b010, 32'h8000_0000, 32'h8000_0000, "R6 mixed high min");
    runOp(3'b010, 32'h7fff_ffff, 32'hffff_ffff, "R6 mixed high positive");
    runOp(3'b011, 32'hffff_ffff, 32'hffff_ffff, "R7 unsigned high all ones");
    runOp(3'b011, 32'h8000_0000, 32'h8000_0000, "R7 unsigned high min");

    idleOp(mkInsn(7'b0000001, 3'b000, 7'b0110111), "R3 wrong opcode ignored");
    idleOp(mkInsn(7'b0000000, 3'b000, 7'b0110011), "R3 plain add ignored");
    idleOp(mkInsn(7'b0000001, 3'b100, 7'b0110011), "R3 divide code ignored");
    idleOp(mkInsn(7'b0000001, 3'b111, 7'b0110011), "R3 remainder code ignored");

    // R10 abort in the middle of a high-half run
    @(negedge clk);
    reqInsn  = mkInsn(7'b0000001, 3'b001, 7'b0110011);
    reqOpA   = 32'h1111_1111;
    reqOpB   = 32'h2222_2222;
    reqValid = 1'b1;
    repeat (10) @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    chk(!rspWait && !rspReady, "R10 abort clears wait", 64'({rspWait, rspReady}), 64'h0);
    begin
      bit stray;
      stray = 1'b0;
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        if (rspReady || rspWait) stray = 1'b1;
      end
      chk(!stray, "R10 no ready after abort", 64'(stray), 64'h0);
    end
    runOp(3'b011, 32'hcafe_f00d, 32'h0bad_cafe, "R10 request after abort");

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R9 every request answered", 64'(expQ.size()), 64'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule